// File: doc/BRIEF.md
# Low-Frequency Tick Timer

This block turns a 256 Hz time base into a small real-time divider. The time base comes in as a one-cycle enable pulse (`osc_tick`) in the block's own clock domain. While the timer is running, each pulse advances an 8-bit binary counter. Bit 0 of the counter toggles at 128 Hz and bit 7 completes one period per second. Software or a neighbouring controller can read the counter value directly.

Four of the counter stages raise events: the 32 Hz, 8 Hz, 2 Hz and 1 Hz stages. When a stage's bit goes from 1 to 0 because the counter advanced, the matching sticky flag is set. Each flag is cleared by writing a 1 to it. A flag drives its interrupt line only while its enable bit is set.

Two controls govern counting. A run bit starts and stops the counter, and a clear strobe returns the counter to zero. The clear strobe does not touch the run bit, and it reads back as 0.

Top module: `lftick_timer`

## Requirements
- R1: After reset the counter is 0x00, the run bit is 0, all four enables are 0, all four flags are 0 and no interrupt line is active.
- R2: While the run bit is 1, each cycle with `osc_tick` high and `cnt_clr` low adds one to the counter, modulo 256. The new value is visible after that clock edge.
- R3: While the run bit is 0, the counter keeps its value whatever `osc_tick` does. Once cleared, it holds 0x00.
- R4: A cycle with `cnt_clr` high makes the counter 0x00 after the edge. This overrides a simultaneous advance and leaves the run bit unchanged.
- R5: `ctl_rd[0]` reads the run bit. `ctl_rd[1]` is the readback of the clear strobe and always reads 0.
- R6: Flag index 0 watches counter bit 2 (32 Hz), index 1 watches bit 4 (8 Hz), index 2 watches bit 6 (2 Hz) and index 3 watches bit 7 (1 Hz). A flag is set after an advance that takes its bit from 1 to 0. A clear strobe that zeroes the counter sets no flag.
- R7: A 1 in bit i of `flag_clr` clears flag i after the edge. If a set and a clear happen in the same cycle, the set wins. A 0 bit has no effect.
- R8: `irq[i]` is high exactly when flag i and enable i are both 1, and `irq_any` is the OR of the four lines. Enables are loaded from `en_d` in a cycle with `en_we` high.
- R9: A flag is set by its stage edge even when its enable is 0. In that case the interrupt line stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| osc_tick | input | 1 | 256 Hz time-base pulse, one cycle wide |
| run_we | input | 1 | Load the run bit from run_d |
| run_d | input | 1 | New run bit value |
| cnt_clr | input | 1 | Clear strobe for the counter |
| flag_clr | input | 4 | Write-1-to-clear mask for the flags |
| en_we | input | 1 | Load the interrupt enables from en_d |
| en_d | input | 4 | New interrupt enable values |
| count | output | 8 | Counter value |
| ctl_rd | output | 2 | Control readback: bit 0 run, bit 1 clear strobe (always 0) |
| flag | output | 4 | Sticky stage-edge flags |
| irq | output | 4 | Per-stage interrupt requests |
| irq_any | output | 1 | OR of all interrupt requests |

## Verification
Some rules are checked on every cycle by properties. The counter must either step by one, hold, or drop to zero according to the run bit, the tick and the clear strobe. A flag must follow its set and clear inputs. The run bit must survive a clear strobe. An interrupt must never appear without an enable.

Other behaviour can only be shown by bench scenarios. These are the mapping of each flag to its exact counter stage, the absence of a flag when a clear strobe takes a stage bit from 1 to 0, the wrap from 0xFF, and flags that are latched with their enable off and raise an interrupt only when the enable is turned on later.

// File: rtl/lft_pkg.sv
package lft_pkg;

  localparam int LFT_CNT_W = 8;
  localparam int LFT_NTAP  = 4;

  // Counter bit watched by each event index.
  // With a 256 Hz input, bit k has a period of 2^(k+1)/256 s.
  function automatic int tap_pos(input int idx);
    case (idx)
      0:       tap_pos = 2;  // 32 Hz
      1:       tap_pos = 4;  // 8 Hz
      2:       tap_pos = 6;  // 2 Hz
      default: tap_pos = 7;  // 1 Hz
    endcase
  endfunction

endpackage

// File: rtl/lft_ctrl.sv
module lft_ctrl #(
  parameter int NTAP = lft_pkg::LFT_NTAP
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_we,
  input  logic            run_d,
  input  logic            en_we,
  input  logic [NTAP-1:0] en_d,
  output logic            run_q,
  output logic [NTAP-1:0] en_q
);

  logic            run_nxt;
  logic [NTAP-1:0] en_nxt;

  always_comb begin
    run_nxt = run_q;
    en_nxt  = en_q;
    if (run_we) run_nxt = run_d;
    if (en_we)  en_nxt  = en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      en_q  <= '0;
    end else begin
      run_q <= run_nxt;
      en_q  <= en_nxt;
    end
  end

endmodule

// File: rtl/lft_divider.sv
module lft_divider #(
  parameter int CNT_W = lft_pkg::LFT_CNT_W,
  parameter int NTAP  = lft_pkg::LFT_NTAP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic [NTAP-1:0]  fall
);

  logic             adv;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_nxt;

  assign adv     = run && tick && !clr;
  assign cnt_inc = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};

  always_comb begin
    cnt_nxt = cnt_q;
    if (clr)      cnt_nxt = '0;
    else if (adv) cnt_nxt = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  // Stage edge detection: only an advance can produce an event.
  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    localparam int P = lft_pkg::tap_pos(g);
    assign fall[g] = adv && cnt_q[P] && !cnt_inc[P];
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !clr) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt_q)); // R3
  AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/lft_flag.sv
module lft_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr_w,
  output logic flag_q
);

  logic flag_nxt;

  always_comb begin
    flag_nxt = flag_q;
    if (clr_w) flag_nxt = 1'b0;
    if (set)   flag_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_nxt;
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag_q); // R6
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w && !set) |=> !flag_q); // R7
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_w && !set) |=> $stable(flag_q)); // R7

endmodule

// File: rtl/lftick_timer.sv
module lftick_timer #(
  parameter int CNT_W = lft_pkg::LFT_CNT_W,
  parameter int NTAP  = lft_pkg::LFT_NTAP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             run_we,
  input  logic             run_d,
  input  logic             cnt_clr,
  input  logic [NTAP-1:0]  flag_clr,
  input  logic             en_we,
  input  logic [NTAP-1:0]  en_d,
  output logic [CNT_W-1:0] count,
  output logic [1:0]       ctl_rd,
  output logic [NTAP-1:0]  flag,
  output logic [NTAP-1:0]  irq,
  output logic             irq_any
);

  logic            run_q;
  logic [NTAP-1:0] en_q;
  logic [NTAP-1:0] fall;

  lft_ctrl #(.NTAP(NTAP)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_we (run_we),
    .run_d  (run_d),
    .en_we  (en_we),
    .en_d   (en_d),
    .run_q  (run_q),
    .en_q   (en_q)
  );

  lft_divider #(.CNT_W(CNT_W), .NTAP(NTAP)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (osc_tick),
    .run   (run_q),
    .clr   (cnt_clr),
    .cnt_q (count),
    .fall  (fall)
  );

  for (genvar g = 0; g < NTAP; g++) begin : g_flag
    lft_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (fall[g]),
      .clr_w  (flag_clr[g]),
      .flag_q (flag[g])
    );
  end

  assign irq     = flag & en_q;
  assign irq_any = |irq;
  assign ctl_rd  = {1'b0, run_q};

  AST_RUN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_clr && !run_we) |=> $stable(run_q)); // R4
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> (|en_q)); // R8
  AST_NO_FLAG_ON_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |-> (fall == '0)); // R6

endmodule

// File: tb/sim_lftick_timer.sv
`timescale 1ns/1ps
module sim_lftick_timer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       osc_tick, run_we, run_d, cnt_clr, en_we;
  logic [3:0] flag_clr, en_d;
  logic [7:0] count;
  logic [1:0] ctl_rd;
  logic [3:0] flag, irq;
  logic       irq_any;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // bench model state
  logic [7:0] m_cnt;
  logic       m_run;
  logic [3:0] m_en, m_flag;

  always #2.5 clk = ~clk;

  lftick_timer u0 (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .run_we(run_we),
    .run_d(run_d), .cnt_clr(cnt_clr), .flag_clr(flag_clr), .en_we(en_we),
    .en_d(en_d), .count(count), .ctl_rd(ctl_rd), .flag(flag), .irq(irq),
    .irq_any(irq_any)
  );

  function automatic int tapbit(input int i);
    case (i)
      0: return 2;
      1: return 4;
      2: return 6;
      default: return 7;
    endcase
  endfunction

  function automatic logic [7:0] exp_cnt(input logic [7:0] c, input logic run,
                                         input logic tk, input logic clr);
    if (clr) return 8'h00;
    if (run && tk) return c + 8'd1;
    return c;
  endfunction

  function automatic logic [3:0] exp_fall(input logic [7:0] c, input logic run,
                                          input logic tk, input logic clr);
    logic [7:0] n;
    logic [3:0] f;
    f = 4'h0;
    n = c + 8'd1;
    if (run && tk && !clr)
      for (int i = 0; i < 4; i++)
        f[i] = c[tapbit(i)] && !n[tapbit(i)];
    return f;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string ctag, input string ftag);
    chk(ctag, count, m_cnt);
    chk(ftag, flag, m_flag);
    chk("R8 irq", irq, m_flag & m_en);
    chk("R8 irq_any", irq_any, |(m_flag & m_en));
    chk("R5 ctl_rd", ctl_rd, {1'b0, m_run});
  endtask

  // One clock: model follows the inputs held across the edge, then compare.
  task automatic step();
    string ct, ft;
    @(posedge clk);
    ct = cnt_clr ? "R4 count" : ((m_run && osc_tick) ? "R2 count" : "R3 count");
    ft = (flag_clr != 0) ? "R7 flag" : "R6 flag";
    m_flag = (m_flag & ~flag_clr) | exp_fall(m_cnt, m_run, osc_tick, cnt_clr);
    m_cnt  = exp_cnt(m_cnt, m_run, osc_tick, cnt_clr);
    if (run_we) m_run = run_d;
    if (en_we)  m_en  = en_d;
    #1;
    compare_all(ct, ft);
  endtask

  task automatic idle_inputs();
    osc_tick = 0; run_we = 0; run_d = 0; cnt_clr = 0;
    en_we = 0; en_d = 0; flag_clr = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    idle_inputs();
    rst_n = 0;
    m_cnt = 0; m_run = 0; m_en = 0; m_flag = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 run", ctl_rd, 0);
    chk("R1 flag", flag, 0);
    chk("R1 irq", {irq_any, irq}, 0);
    @(negedge clk) rst_n = 1;

    // R3: ticks while stopped do nothing
    osc_tick = 1;
    repeat (5) step();

    // R9: start with enables off, run past the 1 Hz edge
    run_we = 1; run_d = 1; step(); run_we = 0;
    repeat (256) step();
    chk("R9 flag latched with enable off", flag, 4'hF);
    chk("R9 irq low", {irq_any, irq}, 0);
    chk("R2 wrap", count, 8'h00);

    // R8: enable afterwards, irq appears
    osc_tick = 0; en_we = 1; en_d = 4'b1010; step(); en_we = 0;
    chk("R8 late enable", irq, 4'b1010);

    // R7: clear flag 1 while leaving others
    flag_clr = 4'b0010; step(); flag_clr = 0;
    chk("R7 partial clear", flag, 4'b1101);
    flag_clr = 4'hF; step(); flag_clr = 0;

    // R7: set and clear together, set wins (count 3 -> 4 drops bit 2? no: use 7->8)
    osc_tick = 1;
    repeat (3) step();              // count 0 -> 3
    chk("R2 count 3", count, 3);
    step();                          // 3 -> 4
    step(); step(); step();          // 4 -> 7
    flag_clr = 4'b0001; step(); flag_clr = 0;  // 7 -> 8, bit 2 falls
    chk("R7 set wins", flag[0], 1);

    // R4/R6: clear strobe with bit 2 high sets no flag, keeps run
    flag_clr = 4'hF; step(); flag_clr = 0;     // count 9
    repeat (3) step();                          // count 12, bit2=1
    cnt_clr = 1; run_we = 0; step(); cnt_clr = 0;
    chk("R4 cleared", count, 0);
    chk("R6 no flag on clear", flag, 0);
    chk("R4 run kept", ctl_rd[0], 1);

    // random phase
    for (int n = 0; n < 6000; n++) begin
      osc_tick = ($urandom % 3) != 0;
      run_we   = ($urandom % 50) == 0;
      run_d    = ($urandom % 4) != 0;
      cnt_clr  = ($urandom % 97) == 0;
      flag_clr = (($urandom % 8) == 0) ? 4'($urandom) : 4'h0;
      en_we    = ($urandom % 30) == 0;
      en_d     = 4'($urandom);
      step();
    end
    idle_inputs();
    step();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule